// File: doc/BRIEF.md
# Phase-Adjustable Clock Output Divider

This block is one output channel of a clock distribution tree. It divides a fast source clock by a programmable integer ratio and produces one divided clock. The first edge can be pushed back by a programmable number of steps, each step half a source period long. Odd ratios still give a 50% duty cycle. An invert control flips the output polarity. The half-period resolution is modelled with a timing clock that runs at twice the source rate. A source-phase enable marks the timing-clock edges that line up with a rising edge of the source.

Every channel fed by the same timing clock, source-phase enable and synchronisation input starts from the same reference edge. Channels with equal settings therefore stay edge-aligned. A realignment happens automatically when reset is released, and again whenever the active-low sync input is pulsed. The ratio, phase and invert settings are captured only during such a realignment. Changing them while the channel is running cannot disturb a period in progress. A running flag reports that the divided clock has produced its first edge since the last realignment.

Top module: `clkdiv_chan`

## Requirements
- R1: While reset is asserted, `clk_div_o` and `running_o` are both 0.
- R2: When reset is released, the channel realigns itself with no sync pulse. The settings present at the first timing-clock edge after release are captured, and the output then follows R3, R5, R6 and R10 from that edge onward.
- R3: For an effective ratio N, the divided level stays high for exactly N timing-clock cycles and low for exactly N cycles. This holds for odd N as well, so the period is 2N half source periods and the duty cycle is 50%.
- R4: A ratio setting of 0 behaves exactly like a ratio of 1, which passes the source clock through: the level changes on every timing-clock edge.
- R5: The phase setting P is 6 bits wide, so it ranges from 0 to 63. Counting starts at the reference edge E (see R10). The first rising edge of the divided level is registered at timing-clock edge E+P, so P=0 puts it at E itself.
- R6: The output is the divided level XOR the captured invert bit. When the invert bit is set, the inactive level and every half-cycle are inverted.
- R7: A sync input value of 0 seen at any edge drives the divided level to 0 after that edge, so the output sits at its inactive level. It also clears `running_o`. Both hold for as long as sync stays at 0.
- R8: The ratio, phase and invert settings are captured only at edges where the channel is realigning: the first edge after reset release, or any edge while sync is at 0. Changes made while the channel is running have no effect on the output until the next realignment.
- R9: `running_o` rises at the same timing-clock edge as the first rising edge of the divided level after a realignment. It stays at 1 until the next reset or sync assertion.
- R10: The reference edge E is the first edge, after the edge that ends the realignment, at which `src_ph_i` is 1. No counting begins before E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, twice the source clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ph_i | input | 1 | 1 on timing-clock edges that coincide with a rising source edge |
| sync_n_i | input | 1 | Active-low realignment request |
| ratio_i | input | 10 | Divide ratio; 0 is treated as 1 |
| phase_i | input | 6 | Start delay in half source periods (0 to 63) |
| invert_i | input | 1 | Output polarity inversion |
| clk_div_o | output | 1 | Divided output clock |
| running_o | output | 1 | Set from the first output edge after a realignment |

## Verification
The assertions assume that `src_ph_i` marks the source's rising edges. In practice that means it is 1 on alternate timing-clock edges. They also assume that `sync_n_i` and the setting inputs change away from the active clock edge. The bench drives every input on the falling clock edge. It produces `src_ph_i` as a strict alternation derived from its own edge counter. It releases sync on both parities of that counter, so the reference edge falls either one or two edges after the release. Settings are held steady through each realigning edge. They are changed mid-run only in the scenario that checks that such changes are ignored.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_ARM   = 2'd1,
    ST_DELAY = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;

  // Effective ratio: a zero setting maps to one (source pass-through).
  function automatic int unsigned eff_ratio(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // True when a level held for (cnt+1) half periods has reached its length.
  function automatic logic level_done(input int unsigned cnt, input int unsigned ratio);
    return (cnt + 1) >= ratio;
  endfunction

endpackage

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow #(
  parameter int RATIO_W = 10,
  parameter int PHASE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               inv_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               inv_o
);
  import clkdiv_pkg::*;

  logic [RATIO_W-1:0] ratio_q;
  logic [PHASE_W-1:0] phase_q;
  logic               inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= RATIO_W'(1);
      phase_q <= '0;
      inv_q   <= 1'b0;
    end else if (load_i) begin
      ratio_q <= RATIO_W'(eff_ratio(int'(ratio_i)));
      phase_q <= phase_i;
      inv_q   <= inv_i;
    end
  end

  assign ratio_o = ratio_q;
  assign phase_o = phase_q;
  assign inv_o   = inv_q;

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable({ratio_q, phase_q, inv_q}));

  // R4
  ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && (ratio_i == '0) |=> (ratio_q == RATIO_W'(1)));

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq #(
  parameter int PHASE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_n_i,
  input  logic               src_ph_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               load_o,
  output logic               start_o,
  output logic               hold_o,
  output logic               running_o
);
  import clkdiv_pkg::*;

  seq_state_e         st_q, st_d;
  logic [PHASE_W-1:0] dly_q, dly_d;

  // Named events for the assertions and the waveform generator.
  logic arm_hit;     // reference source edge seen while armed
  logic delay_done;  // programmed delay has elapsed

  assign arm_hit    = (st_q == ST_ARM) && sync_n_i && src_ph_i;
  assign delay_done = (st_q == ST_DELAY) && sync_n_i && (dly_q == '0);
  assign start_o    = (arm_hit && (phase_i == '0)) || delay_done;
  assign load_o     = (st_q == ST_HOLD);
  assign hold_o     = !sync_n_i;
  assign running_o  = (st_q == ST_RUN);

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    if (!sync_n_i) begin
      st_d  = ST_HOLD;
      dly_d = '0;
    end else begin
      unique case (st_q)
        ST_HOLD: st_d = ST_ARM;
        ST_ARM: begin
          if (src_ph_i) begin
            if (phase_i == '0) begin
              st_d = ST_RUN;
            end else begin
              st_d  = ST_DELAY;
              dly_d = phase_i - PHASE_W'(1);
            end
          end
        end
        ST_DELAY: begin
          if (dly_q == '0) st_d = ST_RUN;
          else             dly_d = dly_q - PHASE_W'(1);
        end
        ST_RUN:  st_d = ST_RUN;
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HOLD;
      dly_q <= '0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
    end
  end

  // R10
  arm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARM) && sync_n_i && !src_ph_i |=> (st_q == ST_ARM));

  // R5
  dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DELAY) |-> (dly_q < phase_i));

  // R7
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_i |=> !running_o);

endmodule

// File: rtl/clkdiv_wave.sv
module clkdiv_wave #(
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic               start_i,
  input  logic               running_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               lvl_o
);
  import clkdiv_pkg::*;

  logic [RATIO_W-1:0] cnt_q;
  logic               lvl_q;
  logic               flip;   // current level has lasted its N half periods

  assign flip = level_done(int'(cnt_q), int'(ratio_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (running_i) begin
      if (flip) begin
        cnt_q <= '0;
        lvl_q <= ~lvl_q;
      end else begin
        cnt_q <= cnt_q + RATIO_W'(1);
      end
    end
  end

  assign lvl_o = lvl_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_i);

  // R7
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !lvl_q);

  // R9
  rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> running_i);

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
  parameter int RATIO_W = 10,
  parameter int PHASE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_ph_i,
  input  logic               sync_n_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic               invert_i,
  output logic               clk_div_o,
  output logic               running_o
);

  logic               load, start, hold, running, lvl;
  logic [RATIO_W-1:0] ratio_sh;
  logic [PHASE_W-1:0] phase_sh;
  logic               inv_sh;

  clkdiv_shadow #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .ratio_i (ratio_i),
    .phase_i (phase_i),
    .inv_i   (invert_i),
    .ratio_o (ratio_sh),
    .phase_o (phase_sh),
    .inv_o   (inv_sh)
  );

  clkdiv_seq #(.PHASE_W(PHASE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n_i  (sync_n_i),
    .src_ph_i  (src_ph_i),
    .phase_i   (phase_sh),
    .load_o    (load),
    .start_o   (start),
    .hold_o    (hold),
    .running_o (running)
  );

  clkdiv_wave #(.RATIO_W(RATIO_W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (hold),
    .start_i   (start),
    .running_i (running),
    .ratio_i   (ratio_sh),
    .lvl_o     (lvl)
  );

  assign clk_div_o = lvl ^ inv_sh;
  assign running_o = running;

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> (clk_div_o == inv_sh));

endmodule

// File: tb/clkdiv_chan_tb_top.sv
module clkdiv_chan_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_ph = 1'b0;
  logic       sync_n = 1'b1;
  logic [9:0] ratio = 10'd4;
  logic [5:0] phase = 6'd3;
  logic       invert = 1'b0;
  logic       clk_div, running;

  int edge_n = 0;
  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;
  // src_ph is 1 at even-numbered edges.
  always @(negedge clk) src_ph <= (((edge_n + 1) % 2) == 0);

  clkdiv_chan dut_i (
    .clk(clk), .rst_n(rst_n), .src_ph_i(src_ph), .sync_n_i(sync_n),
    .ratio_i(ratio), .phase_i(phase), .invert_i(invert),
    .clk_div_o(clk_div), .running_o(running)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected waveform after release edge h.
  function automatic int ref_edge(input int h);
    return (((h + 1) % 2) == 0) ? h + 1 : h + 2;
  endfunction

  task automatic observe(input int h, input int r, input int p, input bit inv,
                         input int ncyc, input string wreq, input string rreq);
    int n, rise, bad_w, bad_r, fa, fe, ra, re;
    n = (r == 0) ? 1 : r;
    rise = ref_edge(h) + p;
    bad_w = 0; bad_r = 0; fa = 0; fe = 0; ra = 0; re = 0;
    for (int i = 0; i < ncyc; i++) begin
      int j;
      bit lvl, e_out, e_run;
      @(negedge clk);
      j = edge_n;
      if (j >= h) begin
        lvl   = (j >= rise) && ((((j - rise) / n) % 2) == 0);
        e_out = lvl ^ inv;
        e_run = (j >= rise);
        if (clk_div !== e_out) begin
          if (bad_w == 0) begin fa = clk_div; fe = e_out; end
          bad_w++;
        end
        if (running !== e_run) begin
          if (bad_r == 0) begin ra = running; re = e_run; end
          bad_r++;
        end
      end
    end
    check(bad_w == 0, wreq, fa, fe);
    check(bad_r == 0, rreq, ra, re);
  endtask

  task automatic resync(input int r, input int p, input bit inv, input int extra, output int h);
    @(negedge clk);
    ratio = 10'(r); phase = 6'(p); invert = inv; sync_n = 1'b0;
    repeat (3 + extra) @(negedge clk);
    sync_n = 1'b1;
    h = edge_n + 1;
  endtask

  task automatic test_reset;
    int h;
    repeat (3) @(negedge clk);
    check(clk_div == 1'b0, "R1 out", clk_div, 0);
    check(running == 1'b0, "R1 running", running, 0);
    rst_n = 1'b1;
    h = edge_n + 1;
    observe(h, 4, 3, 0, 40, "R2 auto-sync waveform", "R9 running after reset");
  endtask

  task automatic test_ratios;
    int h;
    resync(6, 0, 0, 0, h);
    observe(h, 6, 0, 0, 60, "R3 even ratio", "R9 running even");
    resync(5, 1, 0, 0, h);
    observe(h, 5, 1, 0, 60, "R3 odd ratio duty", "R9 running odd");
    resync(1, 0, 0, 0, h);
    observe(h, 1, 0, 0, 20, "R3 ratio one", "R9 running ratio one");
    resync(0, 2, 0, 0, h);
    observe(h, 0, 2, 0, 20, "R4 ratio zero as one", "R9 running ratio zero");
  endtask

  task automatic test_phase;
    int h;
    resync(2, 63, 0, 0, h);
    observe(h, 2, 63, 0, 100, "R5 phase max", "R9 running phase max");
  endtask

  task automatic test_invert;
    int h;
    resync(3, 2, 1, 0, h);
    observe(h, 3, 2, 1, 40, "R6 inverted output", "R9 running inverted");
  endtask

  task automatic test_src_edge;
    int h;
    resync(2, 0, 0, 0, h);
    observe(h, 2, 0, 0, 16, "R10 reference edge parity a", "R10 running parity a");
    resync(2, 0, 0, 1, h);
    observe(h, 2, 0, 0, 16, "R10 reference edge parity b", "R10 running parity b");
  endtask

  task automatic test_sync_hold;
    int h, bad, fa;
    resync(3, 0, 1, 0, h);
    observe(h, 3, 0, 1, 20, "R6 pre-hold waveform", "R9 pre-hold running");
    sync_n = 1'b0;
    bad = 0; fa = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (clk_div !== 1'b1 || running !== 1'b0) begin
        if (bad == 0) fa = {clk_div, running};
        bad++;
      end
    end
    check(bad == 0, "R7 hold level {out,run}", fa, 2);
    sync_n = 1'b1;
    h = edge_n + 1;
    observe(h, 3, 0, 1, 20, "R7 restart after hold", "R9 restart running");
  endtask

  task automatic test_cfg_ignore;
    int h;
    resync(3, 0, 0, 0, h);
    observe(h, 3, 0, 0, 20, "R8 before change", "R9 before change");
    ratio = 10'd7; phase = 6'd5; invert = 1'b1;
    observe(h, 3, 0, 0, 40, "R8 change ignored", "R8 running unaffected");
    resync(7, 5, 1, 0, h);
    observe(h, 7, 5, 1, 50, "R8 applied at sync", "R9 running after apply");
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    test_ratios();
    test_phase();
    test_invert();
    test_src_edge();
    test_sync_hold();
    test_cfg_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule